// File: doc/BRIEF.md
# XGMII Transmit Idle Code Converter

This block sits between a 32-bit, four-lane XGMII transmit source and a four-lane 8b/10b encoder. Each clock it accepts one word of four bytes, each with its own control flag, and produces one word of four lane characters, each with a K-flag, one cycle later. Data bytes pass through untouched. XGMII control codes are mapped to the lane control characters the encoder expects. A start code is accepted only in lane 0. A terminate code may sit in any lane, and the idle bytes that follow it in the same word become /K/ (K28.5).

Clock tolerance compensation is driven from outside through two request inputs. An insert request emits a full word of /R/ (K28.0) in place of the current input word. The upstream source must hold that word and present it again. A drop request removes an all-idle word, and the output valid qualifier stays low for it. Both requests act only in the inter-packet gap. Inside a packet they are ignored, so all four lanes always gain or lose /R/ together and never inside a frame.

Top module: `xgtx_idle_conv`

## Requirements
- R1: While rst_ni is low, vld_o, dat_o and kflag_o are all zero.
- R2: A byte whose control flag is 0 appears unchanged in the same lane one cycle later with its K-flag 0. Lane n is dat_o[8n+7:8n].
- R3: Control byte 0xFB (start) in lane 0 while in the gap is output as 0xFB with K-flag 1 and opens a packet. A start byte in lanes 1 to 3, or in lane 0 inside a packet, is output as 0xFE (K30.7).
- R4: Control byte 0xFD (terminate) in lane n is output as 0xFD and closes the packet. Every control byte 0x07 (idle) in a lane above n in the same word is output as 0xBC (/K/). Lanes below n are converted normally.
- R5: A control 0x07 idle byte that does not follow a terminate byte in its word is output as 0x1C (/R/) with K-flag 1.
- R6: Control bytes in the valid K-character set {0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD, 0xFE} pass with K-flag 1, apart from the cases in R3 and R4. Any other control byte except 0x07 is output as 0xFE.
- R7: In the gap, ins_req_i high produces one output word of 0x1C on all lanes with all K-flags 1 and vld_o 1. The input word that cycle is not consumed and does not change the packet state.
- R8: In the gap, drop_req_i high with ins_req_i low, on an input word whose four bytes are all control 0x07, gives vld_o 0 for that word. If the gap word is not all-idle, the drop request has no effect.
- R9: Between an accepted start and the word that carries its terminate, ins_req_i and drop_req_i are ignored: vld_o is 1 and the word is converted normally.
- R10: When both requests are high in the gap, the insert takes effect and the drop does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 32 | XGMII transmit bytes, lane 0 in bits 7:0 |
| txc_i | input | 4 | Per-lane control flag |
| ins_req_i | input | 1 | Request to insert an /R/ word (input held upstream) |
| drop_req_i | input | 1 | Request to remove an all-idle word |
| dat_o | output | 32 | Lane characters for the encoder |
| kflag_o | output | 4 | Per-lane K-character flag |
| vld_o | output | 1 | Output word qualifier |

## Verification
Packets are sent with the terminate code in each of the four lanes. This separates correct /K/ substitution above the terminate from wrongly rewriting lanes below it or idles in other words. One lane is swept through all 256 control byte values in the gap, which tells the twelve valid K-characters apart from error substitution and from the start and terminate special cases. A run of arithmetic data words inside a packet, with both requests toggling, shows that data passes and that requests are ignored within a frame. Gap words then exercise insert, drop, drop on a non-idle word, and both requests at once, to show that insert takes priority and that the held input word is processed afterwards.

// File: rtl/xgtx_pkg.sv
package xgtx_pkg;
  localparam logic [7:0] XG_IDLE  = 8'h07;
  localparam logic [7:0] XG_START = 8'hFB;
  localparam logic [7:0] XG_TERM  = 8'hFD;
  localparam logic [7:0] LC_R     = 8'h1C;
  localparam logic [7:0] LC_K     = 8'hBC;
  localparam logic [7:0] LC_E     = 8'hFE;

  function automatic logic is_kchar(input logic [7:0] b);
    case (b)
      8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
      8'hF7, 8'hFB, 8'hFD, 8'hFE: is_kchar = 1'b1;
      default:                    is_kchar = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xgtx_lane_map.sv
module xgtx_lane_map
  import xgtx_pkg::*;
#(
  parameter bit FIRST = 1'b0
) (
  input  logic [7:0] byte_i,
  input  logic       ctrl_i,
  input  logic       gap_i,
  input  logic       after_term_i,
  output logic [7:0] byte_o,
  output logic       k_o,
  output logic       is_term_o,
  output logic       is_idle_o,
  output logic       is_start_o
);
  assign is_term_o  = ctrl_i && (byte_i == XG_TERM);
  assign is_idle_o  = ctrl_i && (byte_i == XG_IDLE);
  assign is_start_o = ctrl_i && (byte_i == XG_START);

  always_comb begin
    k_o    = ctrl_i;
    byte_o = byte_i;
    if (ctrl_i) begin
      if (byte_i == XG_IDLE) begin
        byte_o = after_term_i ? LC_K : LC_R;
      end else if (byte_i == XG_START) begin
        // start only valid in lane 0 and only from the gap
        byte_o = (FIRST && gap_i) ? XG_START : LC_E;
      end else if (!is_kchar(byte_i)) begin
        byte_o = LC_E;
      end
    end
  end
endmodule

// File: rtl/xgtx_term_scan.sv
module xgtx_term_scan #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] is_term_i,
  output logic [LANES-1:0] after_term_o,
  output logic             any_term_o
);
  logic [LANES:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < LANES; i++) begin : g_scan
    assign after_term_o[i] = seen[i];
    assign seen[i+1]       = seen[i] | is_term_i[i];
  end
  assign any_term_o = seen[LANES];
endmodule

// File: rtl/xgtx_rate_ctl.sv
module xgtx_rate_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ins_req_i,
  input  logic drop_req_i,
  input  logic all_idle_i,
  input  logic any_term_i,
  input  logic start0_i,
  output logic gap_o,
  output logic ins_take_o,
  output logic drop_take_o
);
  logic in_pkt_q, in_pkt_d;

  assign gap_o       = !in_pkt_q;
  assign ins_take_o  = ins_req_i && gap_o;
  assign drop_take_o = !ins_req_i && drop_req_i && gap_o && all_idle_i;

  always_comb begin
    in_pkt_d = in_pkt_q;
    if (!ins_take_o && !drop_take_o) begin
      if (any_term_i)              in_pkt_d = 1'b0;
      else if (start0_i && gap_o)  in_pkt_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_pkt_q <= 1'b0;
    else         in_pkt_q <= in_pkt_d;
  end
endmodule

// File: rtl/xgtx_idle_conv.sv
module xgtx_idle_conv
  import xgtx_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    txd_i,
  input  logic [LANES-1:0] txc_i,
  input  logic             ins_req_i,
  input  logic             drop_req_i,
  output logic [DW-1:0]    dat_o,
  output logic [LANES-1:0] kflag_o,
  output logic             vld_o
);
  logic [DW-1:0]    map_dat;
  logic [LANES-1:0] map_k, is_term, is_idle, is_start, after_term;
  logic             any_term, gap, ins_take, drop_take;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    xgtx_lane_map #(.FIRST(i == 0)) u_map (
      .byte_i      (txd_i[8*i +: 8]),
      .ctrl_i      (txc_i[i]),
      .gap_i       (gap),
      .after_term_i(after_term[i]),
      .byte_o      (map_dat[8*i +: 8]),
      .k_o         (map_k[i]),
      .is_term_o   (is_term[i]),
      .is_idle_o   (is_idle[i]),
      .is_start_o  (is_start[i])
    );
  end

  xgtx_term_scan #(.LANES(LANES)) u_scan (
    .is_term_i   (is_term),
    .after_term_o(after_term),
    .any_term_o  (any_term)
  );

  xgtx_rate_ctl u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_req_i  (ins_req_i),
    .drop_req_i (drop_req_i),
    .all_idle_i (&is_idle),
    .any_term_i (any_term),
    .start0_i   (is_start[0]),
    .gap_o      (gap),
    .ins_take_o (ins_take),
    .drop_take_o(drop_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o   <= '0;
      kflag_o <= '0;
      vld_o   <= 1'b0;
    end else if (ins_take) begin
      dat_o   <= {LANES{LC_R}};
      kflag_o <= '1;
      vld_o   <= 1'b1;
    end else begin
      dat_o   <= map_dat;
      kflag_o <= map_k;
      vld_o   <= !drop_take;
    end
  end
endmodule

// File: rtl/xgtx_idle_conv_chk.sv
module xgtx_idle_conv_chk #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DW-1:0]    txd_i,
  input logic [LANES-1:0] txc_i,
  input logic             ins_req_i,
  input logic             drop_req_i,
  input logic [DW-1:0]    dat_o,
  input logic [LANES-1:0] kflag_o,
  input logic             vld_o,
  input logic             gap_i
);
  logic [LANES-1:0] idle_l;
  for (genvar i = 0; i < LANES; i++) begin : g_idle
    assign idle_l[i] = txc_i[i] && (txd_i[8*i +: 8] == 8'h07);
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (!vld_o && dat_o == '0 && kflag_o == '0));

  p_data_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc_i == '0 && !ins_req_i) |=> (vld_o && kflag_o == '0 && dat_o == $past(txd_i)));

  for (genvar i = 1; i < LANES; i++) begin : g_start
    p_lane_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> !(kflag_o[i] && dat_o[8*i +: 8] == 8'hFB));
  end

  p_ins_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_req_i && gap_i) |=> (vld_o && kflag_o == '1 && dat_o == {LANES{8'h1C}}));

  p_drop_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_req_i && drop_req_i && gap_i && &idle_l) |=> !vld_o);

  p_in_pkt_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gap_i |=> vld_o);
endmodule

bind xgtx_idle_conv xgtx_idle_conv_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_i(txd_i), .txc_i(txc_i),
  .ins_req_i(ins_req_i), .drop_req_i(drop_req_i), .dat_o(dat_o),
  .kflag_o(kflag_o), .vld_o(vld_o), .gap_i(gap)
);

// File: tb/xgtx_idle_conv_tb.sv
module xgtx_idle_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] txd = 32'h07070707;
  logic [3:0]  txc = 4'hF;
  logic        ins = 1'b0, drp = 1'b0;
  logic [31:0] dat;
  logic [3:0]  kf;
  logic        vld;
  int checks = 0, errors = 0;
  bit ip = 1'b0;

  always #10 clk = ~clk;

  xgtx_idle_conv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .txc_i(txc),
    .ins_req_i(ins), .drop_req_i(drp), .dat_o(dat), .kflag_o(kf), .vld_o(vld)
  );

  function automatic bit valid_k(input logic [7:0] b);
    return (b[4:0] == 5'h1C) || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
  endfunction

  task automatic model(input logic [31:0] d, input logic [3:0] c, input bit ri, input bit rd,
                       output logic [31:0] eo, output logic [3:0] ek, output bit ev);
    bit tseen = 1'b0, all_idle = 1'b1;
    for (int i = 0; i < 4; i++) all_idle &= c[i] && d[8*i +: 8] == 8'h07;
    eo = 32'h0; ek = 4'h0; ev = 1'b1;
    if (!ip && ri) begin
      eo = 32'h1C1C1C1C; ek = 4'hF; return;
    end
    if (!ip && rd && all_idle) begin
      ev = 1'b0; return;
    end
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = d[8*i +: 8];
      logic [7:0] o = b;
      if (c[i]) begin
        if (b == 8'h07)      o = tseen ? 8'hBC : 8'h1C;
        else if (b == 8'hFB) o = (i == 0 && !ip) ? 8'hFB : 8'hFE;
        else if (!valid_k(b)) o = 8'hFE;
        if (b == 8'hFD) tseen = 1'b1;
      end
      eo[8*i +: 8] = o; ek[i] = c[i];
    end
    if (tseen) ip = 1'b0;
    else if (c[0] && d[7:0] == 8'hFB && !ip) ip = 1'b1;
  endtask

  task automatic step(input logic [31:0] d, input logic [3:0] c, input bit ri, input bit rd,
                      input string tag);
    logic [31:0] eo; logic [3:0] ek; bit ev;
    txd = d; txc = c; ins = ri; drp = rd;
    model(d, c, ri, rd, eo, ek, ev);
    @(negedge clk);
    checks++;
    if (vld !== ev || (ev && (dat !== eo || kf !== ek))) begin
      errors++;
      $display("FAIL %s: vld=%0b dat=%h k=%h expected vld=%0b dat=%h k=%h",
               tag, vld, dat, kf, ev, eo, ek);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (vld !== 1'b0 || dat !== 32'h0 || kf !== 4'h0) begin
      errors++;
      $display("FAIL R1: vld=%0b dat=%h k=%h expected 0 0 0", vld, dat, kf);
    end
    rst_n = 1'b1;
    @(negedge clk);

    step(32'h07070707, 4'hF, 0, 0, "R5 idle word");

    // terminate in each lane
    for (int t = 0; t < 4; t++) begin
      logic [31:0] tw; logic [3:0] tc;
      step(32'h332211FB, 4'h1, 0, 0, "R3 start lane0");
      step(32'h77665544 + t, 4'h0, 0, 0, "R2 payload");
      for (int i = 0; i < 4; i++) begin
        if (i < t)       begin tw[8*i +: 8] = 8'h10 + 8'(i); tc[i] = 1'b0; end
        else if (i == t) begin tw[8*i +: 8] = 8'hFD;         tc[i] = 1'b1; end
        else             begin tw[8*i +: 8] = 8'h07;         tc[i] = 1'b1; end
      end
      step(tw, tc, 0, 0, "R4 terminate lane");
      step(32'h07070707, 4'hF, 0, 0, "R5 idle after term");
    end

    // exhaustive control byte in lane 1 during gap
    for (int v = 0; v < 256; v++)
      step({16'h0707, 8'(v), 8'h07}, 4'hF, 0, 0, "R6 ctrl sweep lane1");

    // data inside a packet, requests toggling
    step(32'h000000FB, 4'h1, 0, 0, "R3 start");
    for (int n = 0; n < 64; n++)
      step(32'h01010101 * n + 32'h03020100 ^ (32'(n) << 24), 4'h0, n[0], n[1], "R9 R2 data in packet");
    step(32'h07070707, 4'hF, 1, 1, "R9 idle ctrl in packet with requests");
    step(32'h5AFB0000, 4'h4, 0, 0, "R3 start lane2 in packet");
    step(32'h07FD0000, 4'hC, 0, 0, "R4 close");

    // gap rate compensation
    step(32'h000000FB, 4'h1, 1, 0, "R7 insert holds start");
    step(32'h000000FB, 4'h1, 0, 0, "R7 held start consumed");
    step(32'h0707FD11, 4'hE, 1, 1, "R9 requests ignored on term word");
    step(32'h07070707, 4'hF, 0, 1, "R8 drop idle");
    step(32'h079C0707, 4'hF, 0, 1, "R8 drop refused non-idle");
    step(32'h07070707, 4'hF, 1, 1, "R10 insert over drop");
    step(32'h07070707, 4'hF, 0, 0, "R5 idle");
    step(32'hFB0707FB, 4'h9, 0, 0, "R3 start lane0 and lane3");
    step(32'h07FD0000, 4'hC, 0, 0, "R4 close");
    step(32'h07070707, 4'hF, 0, 0, "R5 idle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule